// File: doc/BRIEF.md
# Event Performance Monitor

This block counts what a processor core is doing so that software can sample it. It holds one free-running cycle counter and four programmable event counters, all 32 bits wide. Each event counter is given an 8-bit event code. The code picks one line of a 256-line event bus, and the counter advances on every cycle in which that line is high. One global enable gates all counting. Each counter also has its own enable bit, which software sets and clears through separate write-one-to-set and write-one-to-clear registers.

Software reaches the block through a plain single-cycle register port. A write is taken on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`, so the port has no back-pressure and no wait states. The four event counters share one indirect window. A select register chooses which event counter the count and event-code registers address. Sampling works by preloading the two's complement of a period: the counter wraps from all-ones to zero after that many events. The wrap sets a sticky overflow flag, and when that flag is also interrupt-enabled, `irq` is raised.

Top module: `evmon_top`

## Requirements
- R1: After reset, every counter, enable, interrupt enable, flag, event code and the select register are zero, and `irq` is low.
- R2: The cycle counter (count register at address 8) advances by one on each clock while the global enable (control register, address 0, bit 0) and its own enable bit 31 are both set. No counter changes while the global enable is 0.
- R3: Event counter i advances by one on a clock where the global enable and enable bit i are set and the event-bus line indexed by its 8-bit code is high. Other event-bus lines have no effect on it.
- R4: A write to address 1 sets the enable bits written as 1, and a write to address 2 clears them. Zero bits leave enables unchanged. Bits 0-3 are the event counters and bit 31 is the cycle counter. Reads of either address return the enable mask, and all other bits read as zero.
- R5: The select register (address 5, bits 1:0) picks the event counter that address 6 (event code, bits 7:0) and address 7 (count value) access. Higher bits written to either register are ignored.
- R6: A write to address 7 or 8 loads the written value into the selected event counter or into the cycle counter. A load takes precedence over an increment in the same cycle.
- R7: When a counter increments from 0xFFFFFFFF to 0, its overflow flag is set (bit i for event counter i, bit 31 for the cycle counter). The flags read at address 4 and stay set until a write to address 4 with a 1 in that bit position clears them.
- R8: A write to address 3 sets interrupt-enable bits for the ones written, using the same bit layout as R4, and reads return the mask. `irq` is high exactly when some flag is set and its interrupt enable is also set.
- R9: In a write to address 0, bit 1 clears all event counters and bit 2 clears the cycle counter. Both bits act once and read back as zero, while bit 0 reads back as the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, taken on the rising edge |
| reg_addr | input | 4 | Register address (write and combinational read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| evt_bus | input | 256 | Event lines, one per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a counter wrap, because a free run would take four billion cycles. The bench preloads a counter a few counts below all-ones through the indirect window and then releases a short burst of events, so each wrap lands within a handful of cycles. A second awkward case is a load and an increment arriving in the same cycle. The bench reaches it by holding an event line high with counting enabled while it writes the count register, and then checking that the value was loaded without gaining the extra count. The event decoder is swept over several codes per counter, with the other lines both quiet and saturated, so that any decode from the wrong line shows up as a count mismatch.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CYC_BIT = 31;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_ENSET  = 4'd1,
    RA_ENCLR  = 4'd2,
    RA_INTSET = 4'd3,
    RA_FLAGS  = 4'd4,
    RA_SEL    = 4'd5,
    RA_EVCODE = 4'd6,
    RA_EVCNT  = 4'd7,
    RA_CYCCNT = 4'd8
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_EV  = 1;
  localparam int CTRL_CLR_CYC = 2;
endpackage

// File: rtl/evmon_ctr.sv
module evmon_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          inc,
  output logic [CW-1:0] value,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (clr)  value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + 1'b1;
  end

  // Wrap only on a true increment out of all-ones.
  assign wrap = inc && !clr && !load && (&value);
endmodule

// File: rtl/evmon_evmux.sv
module evmon_evmux #(
  parameter int CODE_W = 8,
  localparam int LINES = 1 << CODE_W
) (
  input  logic [LINES-1:0]  bus,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  assign hit = bus[code];
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int NEV    = 4,
  parameter int CW     = 32,
  parameter int CODE_W = 8,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic [(1<<CODE_W)-1:0] evt_bus,
  output logic                   irq
);
  localparam int SELW  = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int LINES = 1 << CODE_W;

  logic                en_g;
  logic [NEV-1:0]      en_ev, ie_ev, fl_ev, hit, wrap_ev;
  logic                en_cy, ie_cy, fl_cy, wrap_cy;
  logic [SELW-1:0]     sel;
  logic [CODE_W-1:0]   code [NEV];
  logic [CW-1:0]       cnt  [NEV];
  logic [CW-1:0]       cyc_val;
  logic [DW-1:0]       en_rd, ie_rd, fl_rd;

  function automatic logic [DW-1:0] pack_mask(input logic [NEV-1:0] ev, input logic cy);
    logic [DW-1:0] r;
    r = '0;
    r[NEV-1:0] = ev;
    r[CYC_BIT] = cy;
    return r;
  endfunction

  logic wr_ctrl, wr_enset, wr_enclr, wr_intset, wr_flags, wr_sel, wr_code, wr_evcnt, wr_cyc;
  always_comb begin
    wr_ctrl   = reg_wr && (reg_addr == AW'(RA_CTRL));
    wr_enset  = reg_wr && (reg_addr == AW'(RA_ENSET));
    wr_enclr  = reg_wr && (reg_addr == AW'(RA_ENCLR));
    wr_intset = reg_wr && (reg_addr == AW'(RA_INTSET));
    wr_flags  = reg_wr && (reg_addr == AW'(RA_FLAGS));
    wr_sel    = reg_wr && (reg_addr == AW'(RA_SEL));
    wr_code   = reg_wr && (reg_addr == AW'(RA_EVCODE));
    wr_evcnt  = reg_wr && (reg_addr == AW'(RA_EVCNT));
    wr_cyc    = reg_wr && (reg_addr == AW'(RA_CYCCNT));
  end

  // Control, enables and select
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_g  <= 1'b0;
      en_ev <= '0;
      en_cy <= 1'b0;
      ie_ev <= '0;
      ie_cy <= 1'b0;
      sel   <= '0;
    end else begin
      if (wr_ctrl) en_g <= reg_wdata[CTRL_EN_BIT];
      if (wr_enset) begin
        en_ev <= en_ev | reg_wdata[NEV-1:0];
        en_cy <= en_cy | reg_wdata[CYC_BIT];
      end else if (wr_enclr) begin
        en_ev <= en_ev & ~reg_wdata[NEV-1:0];
        en_cy <= en_cy & ~reg_wdata[CYC_BIT];
      end
      if (wr_intset) begin
        ie_ev <= ie_ev | reg_wdata[NEV-1:0];
        ie_cy <= ie_cy | reg_wdata[CYC_BIT];
      end
      if (wr_sel) sel <= reg_wdata[SELW-1:0];
    end
  end

  // Overflow flags: a new wrap wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_ev <= '0;
      fl_cy <= 1'b0;
    end else begin
      fl_ev <= (fl_ev & ~(wr_flags ? reg_wdata[NEV-1:0] : '0)) | wrap_ev;
      fl_cy <= (fl_cy & ~(wr_flags & reg_wdata[CYC_BIT])) | wrap_cy;
    end
  end

  // Event counter slices
  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n)                              code[i] <= '0;
      else if (wr_code && sel == SELW'(i))     code[i] <= reg_wdata[CODE_W-1:0];
    end

    evmon_evmux #(.CODE_W(CODE_W)) u_mux (
      .bus  (evt_bus),
      .code (code[i]),
      .hit  (hit[i])
    );

    evmon_ctr #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (wr_ctrl && reg_wdata[CTRL_CLR_EV]),
      .load     (wr_evcnt && sel == SELW'(i)),
      .load_val (reg_wdata[CW-1:0]),
      .inc      (en_g && en_ev[i] && hit[i]),
      .value    (cnt[i]),
      .wrap     (wrap_ev[i])
    );
  end

  evmon_ctr #(.CW(CW)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (wr_ctrl && reg_wdata[CTRL_CLR_CYC]),
    .load     (wr_cyc),
    .load_val (reg_wdata[CW-1:0]),
    .inc      (en_g && en_cy),
    .value    (cyc_val),
    .wrap     (wrap_cy)
  );

  assign en_rd = pack_mask(en_ev, en_cy);
  assign ie_rd = pack_mask(ie_ev, ie_cy);
  assign fl_rd = pack_mask(fl_ev, fl_cy);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(RA_CTRL):   reg_rdata[CTRL_EN_BIT] = en_g;
      AW'(RA_ENSET),
      AW'(RA_ENCLR):  reg_rdata = en_rd;
      AW'(RA_INTSET): reg_rdata = ie_rd;
      AW'(RA_FLAGS):  reg_rdata = fl_rd;
      AW'(RA_SEL):    reg_rdata[SELW-1:0] = sel;
      AW'(RA_EVCODE): reg_rdata[CODE_W-1:0] = code[sel];
      AW'(RA_EVCNT):  reg_rdata[CW-1:0] = cnt[sel];
      AW'(RA_CYCCNT): reg_rdata[CW-1:0] = cyc_val;
      default:        reg_rdata = '0;
    endcase
  end

  assign irq = |(fl_rd & ie_rd);

  logic unused_lines;
  assign unused_lines = (LINES == 0);
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
  parameter int NEV = 4,
  parameter int CW  = 32,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          irq,
  input logic [DW-1:0] en_mask,
  input logic [DW-1:0] ie_mask,
  input logic [DW-1:0] flag_mask,
  input logic          glob_en,
  input logic [CW-1:0] cyc_val
);
  localparam logic [DW-1:0] VALID = (DW'(1) << 31) | DW'((1 << NEV) - 1);

  logic en_touch, flag_wr, cyc_touch;
  assign en_touch  = reg_wr && (reg_addr == AW'(1) || reg_addr == AW'(2));
  assign flag_wr   = reg_wr && (reg_addr == AW'(4));
  assign cyc_touch = reg_wr && (reg_addr == AW'(8) || (reg_addr == AW'(0) && reg_wdata[2]));

  a_r4_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(1)) |=>
      ((en_mask & $past(reg_wdata) & VALID) == ($past(reg_wdata) & VALID)));

  a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(2)) |=> ((en_mask & $past(reg_wdata)) == '0));

  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_touch |=> $stable(en_mask));

  a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(1) || reg_addr == AW'(2)) |-> ((reg_rdata & ~VALID) == '0));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_mask & $past(flag_mask)) == $past(flag_mask)));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_mask != '0 && ie_mask != '0));

  a_r2_cycle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !cyc_touch) |=> $stable(cyc_val));
endmodule

bind evmon_top evmon_checker #(.NEV(NEV), .CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .en_mask   (en_rd),
  .ie_mask   (ie_rd),
  .flag_mask (fl_rd),
  .glob_en   (en_g),
  .cyc_val   (cyc_val)
);

// File: tb/evmon_top_test.sv
module evmon_top_test;
  localparam logic [3:0] A_CTRL = 0, A_ENSET = 1, A_ENCLR = 2, A_INTSET = 3,
                         A_FLAGS = 4, A_SEL = 5, A_CODE = 6, A_EVCNT = 7, A_CYC = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] evt_bus = '0;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  evmon_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] map5(input int m);
    logic [31:0] r;
    r = 32'(m & 15);
    r[31] = m[4];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);

    // R4: enable set/clear sweep over all 32 combinations
    model = '0;
    for (int m = 0; m < 32; m++) begin
      wr(A_ENSET, map5(m) | 32'h0000_0F00);
      model |= map5(m);
      rd(A_ENSET, v); chk("R4 set readback", v, model);
      wr(A_ENCLR, map5((m * 7 + 3) & 31));
      model &= ~map5((m * 7 + 3) & 31);
      rd(A_ENCLR, v); chk("R4 clear readback", v, model);
    end
    wr(A_ENSET, 32'h0); wr(A_ENCLR, 32'h0);
    rd(A_ENSET, v); chk("R4 zero writes no effect", v, model);
    wr(A_ENCLR, 32'hFFFF_FFFF);
    rd(A_ENSET, v); chk("R4 clear all", v, 32'h0);

    // R5: select width and code width
    wr(A_SEL, 32'h6);
    rd(A_SEL, v); chk("R5 select upper bits ignored", v, 32'h2);
    wr(A_CODE, 32'h00AB_CD12);
    rd(A_CODE, v); chk("R5 code upper bits ignored", v, 32'h12);

    // R3 / R5: event decode sweep, per counter several codes
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 6; k++) begin
        int code, p, n;
        logic [31:0] pre, exp;
        code = (i * 67 + k * 41 + 3) % 256;
        p = k + 2;
        n = 20 + k * 3;
        pre = 32'h1000_0000 * i + 32'(k * 7);
        wr(A_SEL, 32'(i));
        wr(A_CODE, 32'(code));
        wr(A_EVCNT, pre);
        wr(A_ENCLR, 32'hFFFF_FFFF);
        wr(A_ENSET, 32'(1 << i));
        wr(A_CTRL, 32'h1);
        exp = pre;
        for (int c = 0; c < n; c++) begin
          evt_bus = (k % 2 == 1) ? '1 : '0;
          evt_bus[code] = (c % p == 0);
          if (c % p == 0) exp++;
          @(negedge clk);
        end
        evt_bus = '0;
        wr(A_CTRL, 32'h0);
        rd(A_EVCNT, v); chk("R3 event count", v, exp);
        rd(A_CODE, v); chk("R5 code readback", v, 32'(code));
      end
    end

    // R5: each counter kept its own value
    for (int i = 0; i < 4; i++) begin
      wr(A_SEL, 32'(i));
      rd(A_CODE, v); chk("R5 indirect code per counter", v, 32'((i * 67 + 5 * 41 + 3) % 256));
    end

    // R2: global enable off freezes counters even with lines high
    wr(A_SEL, 32'h1);
    rd(A_EVCNT, model);
    wr(A_ENSET, 32'h8000_0002);
    evt_bus = '1;
    repeat (5) @(negedge clk);
    rd(A_EVCNT, v); chk("R2 event frozen when global off", v, model);
    evt_bus = '0;

    // R2 / R9: cycle counter runs with enable, cleared by control bit 2
    wr(A_CTRL, 32'h5);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); chk("R2 cycle count", v, 32'd10);
    repeat (5) @(negedge clk);
    rd(A_CYC, v); chk("R2 cycle frozen", v, 32'd10);
    rd(A_CTRL, v); chk("R9 control reads enable only", v, 32'h0);

    // R9: event clear leaves cycle counter, cycle clear leaves events
    wr(A_SEL, 32'h1);
    wr(A_CTRL, 32'h2);
    rd(A_EVCNT, v); chk("R9 event counters cleared", v, 32'h0);
    rd(A_CYC, v); chk("R9 cycle untouched by event clear", v, 32'd10);
    wr(A_SEL, 32'h3);
    wr(A_EVCNT, 32'h55);
    wr(A_CTRL, 32'h5);
    rd(A_CTRL, v); chk("R9 self-clearing bits read zero", v, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); chk("R9 cycle cleared then one count", v, 32'h1);
    rd(A_EVCNT, v); chk("R9 event untouched by cycle clear", v, 32'h55);

    // R6: load beats simultaneous increment
    wr(A_ENCLR, 32'hFFFF_FFFF);
    wr(A_SEL, 32'h0);
    wr(A_CODE, 32'd5);
    wr(A_ENSET, 32'h1);
    evt_bus[5] = 1'b1;
    wr(A_CTRL, 32'h1);
    wr(A_EVCNT, 32'd100);
    wr(A_CTRL, 32'h0);
    evt_bus = '0;
    rd(A_EVCNT, v); chk("R6 load wins then one increment", v, 32'd101);
    wr(A_CYC, 32'h1234_5678);
    rd(A_CYC, v); chk("R6 cycle load", v, 32'h1234_5678);

    // R7 / R8: event counter 2 wrap
    wr(A_ENCLR, 32'hFFFF_FFFF);
    wr(A_SEL, 32'h2);
    wr(A_CODE, 32'd200);
    wr(A_EVCNT, 32'hFFFF_FFFD);
    wr(A_ENSET, 32'h4);
    wr(A_CTRL, 32'h1);
    for (int c = 0; c < 3; c++) begin
      evt_bus[200] = 1'b1;
      @(negedge clk);
    end
    evt_bus = '0;
    wr(A_CTRL, 32'h0);
    rd(A_EVCNT, v); chk("R7 wrapped to zero", v, 32'h0);
    rd(A_FLAGS, v); chk("R7 flag bit 2 set", v, 32'h4);
    chk("R8 irq low without enable", {31'b0, irq}, 32'h0);
    wr(A_INTSET, 32'h4);
    rd(A_INTSET, v); chk("R8 int enable readback", v, 32'h4);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    wr(A_FLAGS, 32'h8000_0003);
    rd(A_FLAGS, v); chk("R7 other ones do not clear", v, 32'h4);
    wr(A_FLAGS, 32'h4);
    rd(A_FLAGS, v); chk("R7 write one clears", v, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    // R7 / R8: cycle counter wrap sets bit 31
    wr(A_ENCLR, 32'hFFFF_FFFF);
    wr(A_ENSET, 32'h8000_0000);
    wr(A_CYC, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); chk("R7 cycle wrapped", v, 32'h0);
    rd(A_FLAGS, v); chk("R7 cycle flag bit 31", v, 32'h8000_0000);
    chk("R8 irq off, cycle not enabled", {31'b0, irq}, 32'h0);
    wr(A_INTSET, 32'h8000_0000);
    chk("R8 irq on cycle flag", {31'b0, irq}, 32'h1);
    wr(A_FLAGS, 32'h8000_0000);
    chk("R8 irq clears", {31'b0, irq}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule